// File: doc/BRIEF.md
# Glitch-Free Synchronized Clock Stop for Two Clock Groups

This block turns a set of clock outputs on and off without ever producing a short pulse. It serves two independent groups. One is a processor-clock group with a two-flop synchronizer and a long minimum run. The other is a bus-clock group that reacts within one clock, has a short minimum run, and includes one free-running member. Each group takes an asynchronous active-low stop request.

The stop request is captured in the domain of the clock being gated. The resulting run decision is copied into a falling-edge register, and each output is the source clock ANDed with that register. An output therefore stops only after a complete high phase, stays parked low, and restarts with a high phase of full width. A per-output enable mask follows the same falling-edge path, so a disabled output is held low whatever the stop request does.

A mode flag separates the two board modes. In mobile mode the stop requests are honoured. In desktop mode the stop pins carry other functions, so both requests are ignored.

Top module: `clkStopPair`

## Requirements
- R1: While `rstN` is low, every gated output stays low and produces no rising edge.
- R2: A stopped output is parked at logic 0 and shows no edge until it is restarted.
- R3: Every high pulse on every output lasts exactly half a source period. This includes the first pulse after a restart and pulses around enable-mask changes.
- R4: Processor-group latency, with `cpuStopN` changed between rising edges of `cpuClk`. After assertion exactly three more pulses appear and then the outputs go low. After release the next three rising edges give no pulse, and the fourth edge gives the first one. Both latencies are below four clocks.
- R5: Bus-group latency, with `pciStopN` changed between rising edges of `pciClk`. After assertion exactly one more pulse appears. After release the first rising edge is missed and the second edge gives a pulse.
- R6: If `cpuStopN` is asserted again before the processor group has run 100 pulses, the group completes exactly 100 pulses counted from the restart and then stops.
- R7: If `pciStopN` is asserted again before the bus group has run 10 pulses, the group completes exactly 10 pulses and then stops.
- R8: An output whose enable bit is 0 is held low. An output whose enable bit is 1 toggles on every source cycle while its group runs. Bit i of each mask controls output bit i.
- R9: With `mobileMode` at 0, both stop requests are ignored and all enabled outputs run. A group held stopped starts again one source edge after the flag falls.
- R10: The top bit of the bus group (index 6) is never stopped by `pciStopN`. Stopping either group leaves the other group's pulses unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuClk | input | 1 | Processor-group source clock |
| pciClk | input | 1 | Bus-group source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mobileMode | input | 1 | 1 = stop requests honoured, 0 = ignored |
| cpuStopN | input | 1 | Asynchronous active-low processor-group stop request |
| pciStopN | input | 1 | Asynchronous active-low bus-group stop request |
| cpuEnMask | input | 4 | Per-output enable for the processor group |
| pciEnMask | input | 7 | Per-output enable for the bus group; bit 6 is the free-running output |
| cpuClkOut | output | 4 | Gated processor clocks |
| pciClkOut | output | 7 | Gated bus clocks; bit 6 is free-running |

## Verification
The hardest case to reach is a stop request that arrives while the minimum-run window is still open. The stop must then be held back for a pulse count far longer than any latency window. The stimulus releases the stop request and asserts it again a few clocks later, then counts pulses across the whole window. It repeats this with randomly timed stop holds and random masks, while edge-driven monitors time every high pulse of every output for exactly half a period.

// File: rtl/clkStopPkg.sv
package clkStopPkg;

  // Strobe bundle from control to datapath.
  typedef struct packed {
    logic runEn;   // group may toggle during the next source cycle
  } gateStrobeT;

  // Control state width for a given minimum-run count.
  function automatic int runCntWidth(input int minRun);
    return (minRun > 1) ? $clog2(minRun) : 1;
  endfunction

endpackage

// File: rtl/clkStopCtrl.sv
module clkStopCtrl
  import clkStopPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 100
) (
  input  logic       srcClk,
  input  logic       rstN,
  input  logic       mobileMode,
  input  logic       stopReqN,
  output gateStrobeT strobe
);

  localparam int CW = runCntWidth(MIN_RUN);
  localparam logic [CW-1:0] MAXC = CW'(MIN_RUN - 1);

  logic stopSyncN;

  // Request synchronizer; depth zero lets the run register act as first stage
  generate
    if (SYNC_STAGES == 0) begin : gNoSync
      assign stopSyncN = stopReqN;
    end else begin : gSync
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge srcClk or negedge rstN) begin
        if (!rstN) begin
          syncQ <= '1;
        end else begin
          syncQ[0] <= stopReqN;
          for (int s = 1; s < SYNC_STAGES; s++) begin
            syncQ[s] <= syncQ[s-1];
          end
        end
      end
      assign stopSyncN = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  logic          stopActive;
  logic          runQ;
  logic [CW-1:0] runCnt;
  logic          runNext;

  assign stopActive = mobileMode & ~stopSyncN;
  // A running group may only drop once the run counter has saturated
  assign runNext = ~stopActive | (runQ & (runCnt != MAXC));

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b1;
      runCnt <= MAXC;
    end else begin
      runQ <= runNext;
      if (!runQ) begin
        runCnt <= '0;
      end else if (runCnt != MAXC) begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assign strobe.runEn = runQ;

  // Independent run-length tracker for the minimum-run check
  logic [CW:0] runLen;
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      runLen <= (CW+1)'(MIN_RUN);
    end else if (!runQ) begin
      runLen <= '0;
    end else if (runLen < (CW+1)'(MIN_RUN)) begin
      runLen <= runLen + 1'b1;
    end
  end

  AST_MIN_RUN: assert property (@(posedge srcClk) disable iff (!rstN)
    $fell(runQ) |-> (runLen >= (CW+1)'(MIN_RUN)));  // R6, R7

  AST_OFF_LATENCY: assert property (@(posedge srcClk) disable iff (!rstN)
    (stopActive && runCnt == MAXC) |=> !runQ);  // R4

  AST_DESKTOP_RUN: assert property (@(posedge srcClk) disable iff (!rstN)
    !mobileMode |=> runQ);  // R9

endmodule

// File: rtl/clkGateDp.sv
module clkGateDp
  import clkStopPkg::*;
#(
  parameter int                   NUM_OUT   = 4,
  parameter logic [NUM_OUT-1:0]   FREE_MASK = '0
) (
  input  logic               srcClk,
  input  logic               rstN,
  input  gateStrobeT         strobe,
  input  logic [NUM_OUT-1:0] enMask,
  output logic [NUM_OUT-1:0] clkOut
);

  logic [NUM_OUT-1:0] gateQ;

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : gLane
      logic runSel;
      if (FREE_MASK[i]) begin : gFree
        assign runSel = 1'b1;
      end else begin : gStop
        assign runSel = strobe.runEn;
      end

      // Updated on the falling edge: changes only while the clock is low
      always_ff @(negedge srcClk or negedge rstN) begin
        if (!rstN) begin
          gateQ[i] <= 1'b0;
        end else begin
          gateQ[i] <= enMask[i] & runSel;
        end
      end

      assign clkOut[i] = srcClk & gateQ[i];
    end
  endgenerate

  always @(gateQ) begin
    if (rstN) begin
      AST_GATE_WHEN_LOW: assert (!srcClk);  // R3
    end
  end

endmodule

// File: rtl/clkStopGroup.sv
module clkStopGroup
  import clkStopPkg::*;
#(
  parameter int                 NUM_OUT     = 4,
  parameter int                 SYNC_STAGES = 2,
  parameter int                 MIN_RUN     = 100,
  parameter logic [NUM_OUT-1:0] FREE_MASK   = '0
) (
  input  logic               srcClk,
  input  logic               rstN,
  input  logic               mobileMode,
  input  logic               stopReqN,
  input  logic [NUM_OUT-1:0] enMask,
  output logic [NUM_OUT-1:0] clkOut
);

  gateStrobeT strobe;

  clkStopCtrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_RUN    (MIN_RUN)
  ) i_ctrl (
    .srcClk    (srcClk),
    .rstN      (rstN),
    .mobileMode(mobileMode),
    .stopReqN  (stopReqN),
    .strobe    (strobe)
  );

  clkGateDp #(
    .NUM_OUT  (NUM_OUT),
    .FREE_MASK(FREE_MASK)
  ) i_dp (
    .srcClk(srcClk),
    .rstN  (rstN),
    .strobe(strobe),
    .enMask(enMask),
    .clkOut(clkOut)
  );

endmodule

// File: rtl/clkStopPair.sv
module clkStopPair #(
  parameter int NCPU         = 4,
  parameter int NPCI         = 6,
  parameter int CPU_SYNC     = 2,
  parameter int PCI_SYNC     = 0,
  parameter int CPU_MIN_RUN  = 100,
  parameter int PCI_MIN_RUN  = 10
) (
  input  logic            cpuClk,
  input  logic            pciClk,
  input  logic            rstN,
  input  logic            mobileMode,
  input  logic            cpuStopN,
  input  logic            pciStopN,
  input  logic [NCPU-1:0] cpuEnMask,
  input  logic [NPCI:0]   pciEnMask,
  output logic [NCPU-1:0] cpuClkOut,
  output logic [NPCI:0]   pciClkOut
);

  localparam int PCI_W = NPCI + 1;
  localparam logic [PCI_W-1:0] PCI_FREE = PCI_W'(1) << NPCI;

  clkStopGroup #(
    .NUM_OUT    (NCPU),
    .SYNC_STAGES(CPU_SYNC),
    .MIN_RUN    (CPU_MIN_RUN),
    .FREE_MASK  ('0)
  ) i_cpuGrp (
    .srcClk    (cpuClk),
    .rstN      (rstN),
    .mobileMode(mobileMode),
    .stopReqN  (cpuStopN),
    .enMask    (cpuEnMask),
    .clkOut    (cpuClkOut)
  );

  clkStopGroup #(
    .NUM_OUT    (PCI_W),
    .SYNC_STAGES(PCI_SYNC),
    .MIN_RUN    (PCI_MIN_RUN),
    .FREE_MASK  (PCI_FREE)
  ) i_pciGrp (
    .srcClk    (pciClk),
    .rstN      (rstN),
    .mobileMode(mobileMode),
    .stopReqN  (pciStopN),
    .enMask    (pciEnMask),
    .clkOut    (pciClkOut)
  );

endmodule

// File: tb/test_clkStopPair.sv
module test_clkStopPair;

  localparam int CLK_PERIOD  = 10;
  localparam int PCI_PERIOD  = 3 * CLK_PERIOD;
  localparam int NCPU        = 4;
  localparam int NPCI        = 6;
  localparam int CPU_SYNC    = 2;
  localparam int PCI_SYNC    = 0;
  localparam int CPU_MIN     = 100;
  localparam int PCI_MIN     = 10;
  localparam int WATCHDOG    = 150000;

  logic            cpuClk, pciClk, rstN, mobileMode, cpuStopN, pciStopN;
  logic [NCPU-1:0] cpuEnMask, cpuClkOut;
  logic [NPCI:0]   pciEnMask, pciClkOut;

  int total = 0;
  int bad   = 0;
  int cpuCnt [NCPU];
  int pciCnt [NPCI+1];
  time cpuRise [NCPU];
  time pciRise [NPCI+1];

  clkStopPair i_clkStopPair (
    .cpuClk    (cpuClk),
    .pciClk    (pciClk),
    .rstN      (rstN),
    .mobileMode(mobileMode),
    .cpuStopN  (cpuStopN),
    .pciStopN  (pciStopN),
    .cpuEnMask (cpuEnMask),
    .pciEnMask (pciEnMask),
    .cpuClkOut (cpuClkOut),
    .pciClkOut (pciClkOut)
  );

  initial begin
    cpuClk = 1'b0;
    forever #(CLK_PERIOD/2) cpuClk = ~cpuClk;
  end
  initial begin
    pciClk = 1'b0;
    #2;
    forever #(PCI_PERIOD/2) pciClk = ~pciClk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected values derived from the requirements
  function automatic int offPulses(input int syncStages);
    return syncStages + 1;
  endfunction
  function automatic int missedEdges(input int syncStages);
    return syncStages + 1;
  endfunction
  function automatic int expPulses(input logic [7:0] mask, input int b, input int n);
    return mask[b] ? n : 0;
  endfunction

  // Pulse counting and width monitoring (R3)
  for (genvar g = 0; g < NCPU; g++) begin : gCpuMon
    initial cpuCnt[g] = 0;
    always @(posedge cpuClkOut[g]) begin
      cpuCnt[g]++;
      cpuRise[g] = $time;
    end
    always @(negedge cpuClkOut[g]) begin
      if (rstN) chk(($time - cpuRise[g]) == CLK_PERIOD/2, "R3 cpu pulse width",
                    int'($time - cpuRise[g]), CLK_PERIOD/2);
    end
  end
  for (genvar g = 0; g <= NPCI; g++) begin : gPciMon
    initial pciCnt[g] = 0;
    always @(posedge pciClkOut[g]) begin
      pciCnt[g]++;
      pciRise[g] = $time;
    end
    always @(negedge pciClkOut[g]) begin
      if (rstN) chk(($time - pciRise[g]) == PCI_PERIOD/2, "R3 pci pulse width",
                    int'($time - pciRise[g]), PCI_PERIOD/2);
    end
  end

  task automatic cpuEdges(input int n);
    repeat (n) @(posedge cpuClk);
    #1;
  endtask
  task automatic pciEdges(input int n);
    repeat (n) @(posedge pciClk);
    #1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(WATCHDOG * CLK_PERIOD);
    total++;
    bad++;
    $display("FAIL watchdog R1..R10 run actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int c0, f0, p0;
    int seed;
    seed = $urandom(32'h5eed_c10c);
    rstN = 1'b0; mobileMode = 1'b1; cpuStopN = 1'b1; pciStopN = 1'b1;
    cpuEnMask = '1; pciEnMask = '1;

    // R1: reset state
    cpuEdges(6);
    chk(cpuClkOut == '0, "R1 cpu outputs in reset", int'(cpuClkOut), 0);
    chk(cpuCnt[0] + pciCnt[0] + pciCnt[NPCI] == 0, "R1 pulses in reset",
        cpuCnt[0] + pciCnt[0] + pciCnt[NPCI], 0);
    rstN = 1'b1;

    // Main function: free running after reset
    cpuEdges(5);
    c0 = cpuCnt[1];
    cpuEdges(20);
    chk(cpuCnt[1] - c0 == 20, "R8 cpu running all enabled", cpuCnt[1] - c0, 20);

    // R4 off latency
    @(posedge cpuClk); #3; cpuStopN = 1'b0;
    c0 = cpuCnt[0];
    cpuEdges(10);
    chk(cpuCnt[0] - c0 == offPulses(CPU_SYNC), "R4 cpu off latency",
        cpuCnt[0] - c0, offPulses(CPU_SYNC));
    chk(cpuClkOut == '0, "R2 cpu parked low", int'(cpuClkOut), 0);

    // R2 / R10: stays low, bus group undisturbed
    c0 = cpuCnt[3];
    p0 = pciCnt[2];
    cpuEdges(30);
    chk(cpuCnt[3] == c0, "R2 cpu no edges while stopped", cpuCnt[3] - c0, 0);
    chk(pciCnt[2] - p0 >= 9, "R10 pci runs during cpu stop", pciCnt[2] - p0, 10);

    // R4 on latency, then R6 early reassert
    @(posedge cpuClk); #3; cpuStopN = 1'b1;
    c0 = cpuCnt[0];
    cpuEdges(missedEdges(CPU_SYNC));
    chk(cpuCnt[0] == c0, "R4 cpu on latency missed edges", cpuCnt[0] - c0, 0);
    cpuEdges(1);
    chk(cpuCnt[0] - c0 == 1, "R4 cpu first pulse", cpuCnt[0] - c0, 1);
    cpuEdges(2);
    @(posedge cpuClk); #3; cpuStopN = 1'b0;
    cpuEdges(200);
    chk(cpuCnt[0] - c0 == CPU_MIN, "R6 cpu minimum run", cpuCnt[0] - c0, CPU_MIN);
    chk(cpuCnt[2] - c0 == CPU_MIN, "R6 cpu lane2 minimum run", cpuCnt[2] - c0, CPU_MIN);

    // R9: desktop mode ignores held stop
    @(posedge cpuClk); #3; mobileMode = 1'b0;
    c0 = cpuCnt[0];
    cpuEdges(10);
    chk(cpuCnt[0] - c0 == 9, "R9 desktop restarts cpu", cpuCnt[0] - c0, 9);
    p0 = pciCnt[0];
    @(posedge pciClk); #3; pciStopN = 1'b0;
    pciEdges(6);
    chk(pciCnt[0] - p0 == 7, "R9 desktop ignores pci stop", pciCnt[0] - p0, 7);
    pciStopN = 1'b1;
    cpuStopN = 1'b1;
    cpuEdges(4);
    mobileMode = 1'b1;
    cpuEdges(4);

    // R5 off latency, R10 free output and cpu independence
    @(posedge pciClk); #3; pciStopN = 1'b0;
    p0 = pciCnt[0];
    f0 = pciCnt[NPCI];
    c0 = cpuCnt[0];
    pciEdges(5);
    chk(pciCnt[0] - p0 == offPulses(PCI_SYNC), "R5 pci off latency",
        pciCnt[0] - p0, offPulses(PCI_SYNC));
    chk(pciCnt[NPCI] - f0 == 5, "R10 free pci output runs", pciCnt[NPCI] - f0, 5);
    chk(cpuCnt[0] - c0 >= 14, "R10 cpu runs during pci stop", cpuCnt[0] - c0, 15);
    chk(pciClkOut[NPCI-1:0] == '0, "R2 pci parked low", int'(pciClkOut[NPCI-1:0]), 0);

    // R5 on latency, R7 early reassert
    @(posedge pciClk); #3; pciStopN = 1'b1;
    p0 = pciCnt[0];
    pciEdges(missedEdges(PCI_SYNC));
    chk(pciCnt[0] == p0, "R5 pci missed edge", pciCnt[0] - p0, 0);
    pciEdges(1);
    chk(pciCnt[0] - p0 == 1, "R5 pci first pulse", pciCnt[0] - p0, 1);
    @(posedge pciClk); #3; pciStopN = 1'b0;
    pciEdges(30);
    chk(pciCnt[0] - p0 == PCI_MIN, "R7 pci minimum run", pciCnt[0] - p0, PCI_MIN);
    @(posedge pciClk); #3; pciStopN = 1'b1;
    pciEdges(4);

    // R8: random enable masks
    for (int it = 0; it < 8; it++) begin
      logic [7:0] cm, pm;
      cm = 8'($urandom());
      pm = 8'($urandom());
      if (it == 0) begin cm = 8'h0; pm = 8'h40; end
      @(posedge cpuClk); #3;
      cpuEnMask = cm[NCPU-1:0];
      pciEnMask = pm[NPCI:0];
      cpuEdges(3);
      pciEdges(3);
      for (int b = 0; b < NCPU; b++) cpuRise[b] = cpuRise[b];
      begin
        int cs [NCPU];
        int ps [NPCI+1];
        for (int b = 0; b < NCPU; b++) cs[b] = cpuCnt[b];
        for (int b = 0; b <= NPCI; b++) ps[b] = pciCnt[b];
        pciEdges(12);
        for (int b = 0; b < NCPU; b++) begin
          // 12 pci edges span 36 cpu edges; alignment may give 35..37
          if (cm[b]) chk(cpuCnt[b] - cs[b] >= 35 && cpuCnt[b] - cs[b] <= 37,
                         "R8 cpu enabled lane", cpuCnt[b] - cs[b], 36);
          else chk(cpuCnt[b] == cs[b], "R8 cpu disabled lane", cpuCnt[b] - cs[b], 0);
        end
        for (int b = 0; b <= NPCI; b++) begin
          chk(pciCnt[b] - ps[b] == expPulses({1'b0, pm[NPCI:0]}, b, 12),
              "R8 pci lane", pciCnt[b] - ps[b], expPulses({1'b0, pm[NPCI:0]}, b, 12));
        end
      end
    end
    cpuEnMask = '1;
    pciEnMask = '1;

    // Random stop holds; R3 widths monitored throughout
    for (int it = 0; it < 6; it++) begin
      @(posedge cpuClk); #3;
      cpuStopN = ~cpuStopN;
      pciStopN = 1'($urandom_range(0, 1));
      cpuEdges($urandom_range(120, 260));
    end
    @(posedge cpuClk); #3; cpuStopN = 1'b1;
    @(posedge pciClk); #3; pciStopN = 1'b1;
    cpuEdges(200);
    c0 = cpuCnt[3];
    p0 = pciCnt[5];
    cpuEdges(30);
    chk(cpuCnt[3] - c0 == 30, "R2 cpu running after random", cpuCnt[3] - c0, 30);
    chk(pciCnt[5] - p0 >= 9, "R5 pci running after random", pciCnt[5] - p0, 10);

    summary();
    $finish;
  end

endmodule